// File: doc/BRIEF.md
# Indexed CMOS Clock Register Front End

This block puts a byte-wide, index/data register window in front of a real-time clock. Software first writes a 7-bit register number to the index port. It then reads or writes that register through the data port. The window covers the time and date fields, three alarm bytes, four status registers and a battery-backed scratch RAM. The calendar counter lives outside the block and arrives as binary fields on the `live_*` inputs.

Time is never read straight from the live counter. A snapshot register copies the live fields at most once per second, and only while the halt bit is clear. Software can therefore read the hour, minute and second one after another and still get one consistent time. Each field is rendered on the fly as BCD or binary. The hour is rendered in 12- or 24-hour form, both choices set by status B. Every request gets exactly one response in the following cycle, carrying read data and an error flag.

Top module: `cmos_regfile`

## Requirements
- R1: An index-port write keeps only bits 6:0 of the byte as the register number; bit 7 is dropped. An index-port read returns 0xFF and does not change the index.
- R2: Any request whose `req_size` is not 0 (0 means one byte) gets an error response and changes no state: not the index, not any register, not the RAM.
- R3: Status B bit 2 picks the time/date output format: 1 gives plain binary, 0 gives packed BCD (tens in bits 7:4, units in bits 3:0). This applies to registers 0x00 seconds, 0x02 minutes, 0x04 hours, 0x06 weekday, 0x07 day of month, 0x08 month and 0x09 year.
- R4: With status B bit 1 at 1, the hour register returns the 0–23 hour. With bit 1 at 0, it returns (hour mod 12)+1 in the chosen format, with bit 7 set when the 24-hour value is 12 or more.
- R5: Weekday reads as the input plus 1, month reads as the input plus 1, and year reads as the input modulo 100.
- R6: The snapshot copies the live time only when at least `CLKS_PER_SEC` cycles have passed since the last copy and status B bit 7 (halt) is 0. Between copies, and while halted, time reads return the held value.
- R7: Writes to the seven time/date registers are accepted without error and have no effect.
- R8: Alarm registers 0x01, 0x03 and 0x05 store the written byte and return it unchanged in every format mode.
- R9: A write to status A (0x0A) stores the byte with bit 7 cleared.
- R10: A write to status B (0x0B) with bit 6 set is answered with an error and leaves status B unchanged. Any other byte is stored.
- R11: Status C (0x0C) reads 0x00, and a write to it is answered with an error. Status D (0x0D) reads 0x80, and a write to it is accepted and ignored.
- R12: RAM at 0x0E–0x7F reads back what was written. At reset it holds the century (`cfg_century` in BCD) at 0x32, `cfg_lomem` little-endian at 0x34–0x35, and `cfg_himem` little-endian at 0x5B–0x5D. All other bytes are zero.
- R13: Each request is answered by exactly one `resp_valid` pulse in the next cycle. No response is produced during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_port | input | 1 | 0 = index port, 1 = data port |
| req_size | input | 2 | Access width code, 0 = single byte |
| req_wdata | input | 8 | Write byte |
| resp_valid | output | 1 | Response strobe |
| resp_err | output | 1 | Request rejected |
| resp_rdata | output | 8 | Read byte |
| live_sec | input | 6 | Live seconds 0–59 |
| live_min | input | 6 | Live minutes 0–59 |
| live_hour | input | 5 | Live hour 0–23 |
| live_wday | input | 3 | Live weekday 0–6 |
| live_mday | input | 5 | Live day of month 1–31 |
| live_mon | input | 4 | Live month 0–11 |
| live_year | input | 8 | Live years since base century |
| cfg_century | input | 7 | Century number, binary |
| cfg_lomem | input | 16 | Preload for RAM 0x34–0x35 |
| cfg_himem | input | 24 | Preload for RAM 0x5B–0x5D |

## Verification
A corrupted index shows on the very next data-port read as a byte from the wrong register. The bench therefore reads back through a fresh selection after every rejected or malformed access. A snapshot that refreshes at the wrong time shows as a time value that is ahead of or behind the expected one. The halt window and the few cycles just after a refresh pin that down to a single cycle. Wrong format state (BCD/binary or 12/24-hour) appears in the first read of an hour or year after the status B write that changed it.

// File: rtl/cmos_pkg.sv
package cmos_pkg;
   localparam logic [6:0] A_SEC   = 7'h00;
   localparam logic [6:0] A_ALM_S = 7'h01;
   localparam logic [6:0] A_MIN   = 7'h02;
   localparam logic [6:0] A_ALM_M = 7'h03;
   localparam logic [6:0] A_HOUR  = 7'h04;
   localparam logic [6:0] A_ALM_H = 7'h05;
   localparam logic [6:0] A_WDAY  = 7'h06;
   localparam logic [6:0] A_MDAY  = 7'h07;
   localparam logic [6:0] A_MON   = 7'h08;
   localparam logic [6:0] A_YEAR  = 7'h09;
   localparam logic [6:0] A_STA   = 7'h0A;
   localparam logic [6:0] A_STB   = 7'h0B;
   localparam logic [6:0] A_STC   = 7'h0C;
   localparam logic [6:0] A_STD   = 7'h0D;

   localparam int RAM_BASE   = 14;
   localparam int CENTURY_AT = 50;   // 0x32
   localparam int LOMEM_AT   = 52;   // 0x34, 0x35
   localparam int HIMEM_AT   = 91;   // 0x5B .. 0x5D

   localparam logic [1:0] SZ_BYTE = 2'd0;
   localparam int SB_24H  = 1;
   localparam int SB_BIN  = 2;
   localparam int SB_PIE  = 6;
   localparam int SB_HALT = 7;
   localparam int SA_UIP  = 7;
   localparam logic [7:0] SD_POWER_OK = 8'h80;
   localparam int N_FIELDS = 7;

   typedef struct packed {
      logic [7:0] year;
      logic [3:0] mon;
      logic [4:0] mday;
      logic [2:0] wday;
      logic [4:0] hour;
      logic [5:0] min;
      logic [5:0] sec;
   } tod_t;

   function automatic logic [7:0] to_bcd(input logic [6:0] v);
      logic [6:0] tens, ones;
      tens = v / 7'd10;
      ones = v % 7'd10;
      return {tens[3:0], ones[3:0]};
   endfunction

   function automatic logic [7:0] ram_preset(input int a, input logic [7:0] cent,
                                             input logic [15:0] lo, input logic [23:0] hi);
      case (a)
         CENTURY_AT:   return cent;
         LOMEM_AT:     return lo[7:0];
         LOMEM_AT + 1: return lo[15:8];
         HIMEM_AT:     return hi[7:0];
         HIMEM_AT + 1: return hi[15:8];
         HIMEM_AT + 2: return hi[23:16];
         default:      return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/cmos_fmt.sv
module cmos_fmt
   import cmos_pkg::*;
(
   input  logic [6:0] val,
   input  logic       bin_mode,
   output logic [7:0] q
);
   assign q = bin_mode ? {1'b0, val} : to_bcd(val);
endmodule

// File: rtl/cmos_snap.sv
module cmos_snap
   import cmos_pkg::*;
#(
   parameter int CLKS_PER_SEC = 32768
)(
   input  logic clk,
   input  logic rst_n,
   input  logic halt,
   input  tod_t live,
   output tod_t snap
);
   localparam int CW = $clog2(CLKS_PER_SEC + 1);
   localparam logic [CW-1:0] FULL = CW'(CLKS_PER_SEC);

   logic [CW-1:0] since_q;
   logic          due;

   assign due = (since_q >= FULL);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_q <= FULL;
         snap    <= '0;
      end else if (due && !halt) begin
         snap    <= live;
         since_q <= CW'(1);
      end else if (!due) begin
         since_q <= since_q + CW'(1);
      end
   end

   AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      halt |=> $stable(snap)); // R6
   AST_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      (since_q < FULL) |=> $stable(snap)); // R6
endmodule

// File: rtl/cmos_nvram.sv
module cmos_nvram
   import cmos_pkg::*;
#(
   parameter int LAST = 127
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic [7:0]  init_century,
   input  logic [15:0] init_lo,
   input  logic [23:0] init_hi,
   input  logic        we,
   input  logic [6:0]  addr,
   input  logic [7:0]  wdata,
   output logic [7:0]  rdata
);
   localparam int DEPTH = LAST - RAM_BASE + 1;

   logic [7:0] cells [DEPTH];
   logic [6:0] ridx;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cell
      localparam int A = RAM_BASE + g;
      logic [7:0] byte_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            byte_q <= ram_preset(A, init_century, init_lo, init_hi);
         else if (we && addr == 7'(A))
            byte_q <= wdata;
      end
      assign cells[g] = byte_q;
   end

   assign ridx  = addr - 7'(RAM_BASE);
   assign rdata = (int'(addr) >= RAM_BASE && int'(addr) <= LAST) ? cells[ridx] : 8'h00;
endmodule

// File: rtl/cmos_regfile.sv
module cmos_regfile
   import cmos_pkg::*;
#(
   parameter int CLKS_PER_SEC = 32768,
   parameter int RAM_LAST     = 127
)(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        req_valid,
   input  logic        req_write,
   input  logic        req_port,
   input  logic [1:0]  req_size,
   input  logic [7:0]  req_wdata,
   output logic        resp_valid,
   output logic        resp_err,
   output logic [7:0]  resp_rdata,
   input  logic [5:0]  live_sec,
   input  logic [5:0]  live_min,
   input  logic [4:0]  live_hour,
   input  logic [2:0]  live_wday,
   input  logic [4:0]  live_mday,
   input  logic [3:0]  live_mon,
   input  logic [7:0]  live_year,
   input  logic [6:0]  cfg_century,
   input  logic [15:0] cfg_lomem,
   input  logic [23:0] cfg_himem
);
   if (CLKS_PER_SEC < 2) begin : g_bad_rate
      $error("CLKS_PER_SEC must be at least 2");
   end
   if (RAM_LAST < HIMEM_AT + 2 || RAM_LAST > 127) begin : g_bad_ram
      $error("RAM_LAST must cover the preset cells and stay within 7 bits");
   end

   tod_t       live, snap;
   logic [6:0] idx_q;
   logic [7:0] sta_q, stb_q;
   logic [7:0] alarm_q [3];
   logic [1:0] alm_sel;
   logic [7:0] ram_rdata;
   logic [6:0] fld [N_FIELDS];
   logic [7:0] fmt [N_FIELDS];
   logic [4:0] hour_mod, hour_sel;
   logic       pm;
   logic [7:0] rd_mux;
   logic       c_err, idx_we, sta_we, stb_we, alm_we, ram_we;
   logic [7:0] c_data;
   logic       byte_ok;

   assign live = '{year: live_year, mon: live_mon, mday: live_mday, wday: live_wday,
                   hour: live_hour, min: live_min, sec: live_sec};

   cmos_snap #(.CLKS_PER_SEC(CLKS_PER_SEC)) u_snap (
      .clk(clk), .rst_n(rst_n), .halt(stb_q[SB_HALT]), .live(live), .snap(snap));

   cmos_nvram #(.LAST(RAM_LAST)) u_ram (
      .clk(clk), .rst_n(rst_n), .init_century(to_bcd(cfg_century)),
      .init_lo(cfg_lomem), .init_hi(cfg_himem), .we(ram_we && req_valid),
      .addr(idx_q), .wdata(req_wdata), .rdata(ram_rdata));

   // hour presentation
   assign hour_mod = snap.hour % 5'd12;
   assign hour_sel = stb_q[SB_24H] ? snap.hour : hour_mod + 5'd1;
   assign pm       = !stb_q[SB_24H] && (snap.hour >= 5'd12);

   assign fld[0] = {1'b0, snap.sec};
   assign fld[1] = {1'b0, snap.min};
   assign fld[2] = {2'b0, hour_sel};
   assign fld[3] = {4'b0, snap.wday} + 7'd1;
   assign fld[4] = {2'b0, snap.mday};
   assign fld[5] = {3'b0, snap.mon} + 7'd1;
   assign fld[6] = 7'(snap.year % 8'd100);

   for (genvar g = 0; g < N_FIELDS; g++) begin : g_fmt
      cmos_fmt u_fmt (.val(fld[g]), .bin_mode(stb_q[SB_BIN]), .q(fmt[g]));
   end

   assign alm_sel = idx_q[2:1];

   always_comb begin
      case (idx_q)
         A_SEC:   rd_mux = fmt[0];
         A_MIN:   rd_mux = fmt[1];
         A_HOUR:  rd_mux = fmt[2] | {pm, 7'b0};
         A_WDAY:  rd_mux = fmt[3];
         A_MDAY:  rd_mux = fmt[4];
         A_MON:   rd_mux = fmt[5];
         A_YEAR:  rd_mux = fmt[6];
         A_ALM_S: rd_mux = alarm_q[0];
         A_ALM_M: rd_mux = alarm_q[1];
         A_ALM_H: rd_mux = alarm_q[2];
         A_STA:   rd_mux = sta_q;
         A_STB:   rd_mux = stb_q;
         A_STC:   rd_mux = 8'h00;
         A_STD:   rd_mux = SD_POWER_OK;
         default: rd_mux = ram_rdata;
      endcase
   end

   assign byte_ok = (req_size == SZ_BYTE);

   always_comb begin
      c_err  = 1'b0;
      c_data = 8'h00;
      idx_we = 1'b0;
      sta_we = 1'b0;
      stb_we = 1'b0;
      alm_we = 1'b0;
      ram_we = 1'b0;
      if (!byte_ok) begin
         c_err = 1'b1;
      end else if (!req_port) begin
         if (!req_write)                           c_data = 8'hFF;
         else if (int'(req_wdata[6:0]) <= RAM_LAST) idx_we = 1'b1;
         else                                      c_err  = 1'b1;
      end else if (!req_write) begin
         c_data = rd_mux;
      end else begin
         case (idx_q)
            A_ALM_S, A_ALM_M, A_ALM_H: alm_we = 1'b1;
            A_STA:   sta_we = 1'b1;
            A_STB:   if (req_wdata[SB_PIE]) c_err = 1'b1; else stb_we = 1'b1;
            A_STC:   c_err = 1'b1;
            A_SEC, A_MIN, A_HOUR, A_WDAY, A_MDAY, A_MON, A_YEAR, A_STD: ;
            default: ram_we = 1'b1;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         idx_q      <= '0;
         sta_q      <= '0;
         stb_q      <= '0;
         alarm_q    <= '{default: 8'h00};
         resp_valid <= 1'b0;
         resp_err   <= 1'b0;
         resp_rdata <= 8'h00;
      end else begin
         resp_valid <= req_valid;
         resp_err   <= req_valid && c_err;
         resp_rdata <= req_valid ? c_data : 8'h00;
         if (req_valid) begin
            if (idx_we) idx_q <= req_wdata[6:0];
            if (sta_we) sta_q <= {1'b0, req_wdata[6:0]};
            if (stb_we) stb_q <= req_wdata;
            if (alm_we && alm_sel != 2'd3) alarm_q[alm_sel] <= req_wdata;
         end
      end
   end

   AST_IDX_READ_FF: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && !req_port && req_size == SZ_BYTE)
      |=> (resp_rdata == 8'hFF && !resp_err)); // R1
   AST_SIZE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size != SZ_BYTE) |=> resp_err); // R2
   AST_SIZE_NOSTATE: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_size != SZ_BYTE) |=> ($stable(idx_q) && $stable(stb_q) && $stable(sta_q))); // R2
   AST_STB_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_write && req_port && byte_ok && idx_q == A_STB && req_wdata[SB_PIE])
      |=> (resp_err && $stable(stb_q))); // R10
   AST_STD_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_port && byte_ok && idx_q == A_STD)
      |=> (resp_rdata == 8'h80)); // R11
   AST_RESP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> resp_valid); // R13
   AST_RESP_NONE: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !resp_valid); // R13
endmodule

// File: tb/sim_cmos_regfile.sv
module sim_cmos_regfile;
   localparam int CLK_PERIOD = 10;
   localparam int N = 16;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_write = 1'b0, req_port = 1'b0;
   logic [1:0] req_size = 2'd0;
   logic [7:0] req_wdata = 8'h00;
   logic resp_valid, resp_err;
   logic [7:0] resp_rdata;
   logic [5:0] live_sec = 6'd7, live_min = 6'd42;
   logic [4:0] live_hour = 5'd15, live_mday = 5'd28;
   logic [2:0] live_wday = 3'd3;
   logic [3:0] live_mon = 4'd10;
   logic [7:0] live_year = 8'd124;
   logic [6:0] cfg_century = 7'd20;
   logic [15:0] cfg_lomem = 16'h1234;
   logic [23:0] cfg_himem = 24'hABCDEF;

   int checks = 0, failures = 0;
   bit done = 1'b0;
   bit   q_chk[$];
   bit   q_err[$];
   logic [7:0] q_dat[$];
   string q_tag[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   cmos_regfile #(.CLKS_PER_SEC(N)) u0 (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_port(req_port), .req_size(req_size), .req_wdata(req_wdata),
      .resp_valid(resp_valid), .resp_err(resp_err), .resp_rdata(resp_rdata),
      .live_sec(live_sec), .live_min(live_min), .live_hour(live_hour),
      .live_wday(live_wday), .live_mday(live_mday), .live_mon(live_mon),
      .live_year(live_year), .cfg_century(cfg_century), .cfg_lomem(cfg_lomem),
      .cfg_himem(cfg_himem));

   function automatic logic [7:0] bcd(input int v);
      return 8'(((v / 10) << 4) | (v % 10));
   endfunction

   task automatic acc(input bit wr, input bit port, input logic [1:0] sz, input logic [7:0] wd,
                      input bit chk, input bit eerr, input logic [7:0] ed, input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_port = port; req_size = sz; req_wdata = wd;
      q_chk.push_back(chk); q_err.push_back(eerr); q_dat.push_back(ed); q_tag.push_back(tag);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic sel(input logic [7:0] a);
      acc(1'b1, 1'b0, 2'd0, a, 1'b0, 1'b0, 8'h00, "R1");
   endtask

   task automatic rd(input logic [7:0] a, input logic [7:0] e, input string tag);
      sel(a);
      acc(1'b0, 1'b1, 2'd0, 8'h00, 1'b1, 1'b0, e, tag);
   endtask

   task automatic wr(input logic [7:0] a, input logic [7:0] d, input bit eerr, input string tag);
      sel(a);
      acc(1'b1, 1'b1, 2'd0, d, 1'b0, eerr, 8'h00, tag);
   endtask

   // monitor: pops one expectation per response
   always @(negedge clk) begin
      if (rst_n && resp_valid) begin
         if (q_chk.size() == 0) begin
            checks++; failures++;
            $display("FAIL R13 unexpected response actual=1 expected=0");
         end else begin
            bit c, e; logic [7:0] d; string t;
            c = q_chk.pop_front(); e = q_err.pop_front();
            d = q_dat.pop_front(); t = q_tag.pop_front();
            checks++;
            if (resp_err !== e || (c && resp_rdata !== d)) begin
               failures++;
               $display("FAIL %s actual err=%0b data=%02h expected err=%0b data=%02h",
                        t, resp_err, resp_rdata, e, d);
            end
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         failures++; checks++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      checks++;
      if (resp_valid !== 1'b0) begin
         failures++;
         $display("FAIL R13 reset resp_valid actual=%0b expected=0", resp_valid);
      end
      rst_n = 1'b1;
      repeat (3) @(negedge clk);

      // R1 index read, R12 reset preset
      acc(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 8'hFF, "R1");
      rd(8'h32, 8'h20, "R12");
      rd(8'h34, 8'h34, "R12");
      rd(8'h35, 8'h12, "R12");
      rd(8'h5B, 8'hEF, "R12");
      rd(8'h5C, 8'hCD, "R12");
      rd(8'h5D, 8'hAB, "R12");
      rd(8'h40, 8'h00, "R12");

      // reset mode: BCD, 12-hour
      rd(8'h00, bcd(7), "R3");
      rd(8'h02, bcd(42), "R3");
      rd(8'h04, 8'h84, "R4");
      rd(8'h06, bcd(4), "R5");
      rd(8'h07, bcd(28), "R3");
      rd(8'h08, bcd(11), "R5");
      rd(8'h09, bcd(24), "R5");

      wr(8'h0B, 8'h06, 1'b0, "R10");
      rd(8'h04, 8'h0F, "R4");
      rd(8'h02, 8'h2A, "R3");
      rd(8'h09, 8'h18, "R5");
      wr(8'h0B, 8'h04, 1'b0, "R10");
      rd(8'h04, 8'h84, "R4");
      wr(8'h0B, 8'h02, 1'b0, "R10");
      rd(8'h04, 8'h15, "R4");

      // R10 reject periodic-enable write
      wr(8'h0B, 8'h46, 1'b1, "R10");
      rd(8'h0B, 8'h02, "R10");

      // R7 time registers ignore writes
      wr(8'h00, 8'h55, 1'b0, "R7");
      rd(8'h00, bcd(7), "R7");
      wr(8'h09, 8'h99, 1'b0, "R7");
      rd(8'h09, bcd(24), "R7");

      // R8 alarms
      wr(8'h01, 8'hA7, 1'b0, "R8");
      wr(8'h03, 8'h3C, 1'b0, "R8");
      wr(8'h05, 8'hFF, 1'b0, "R8");
      rd(8'h01, 8'hA7, "R8");
      rd(8'h03, 8'h3C, "R8");
      rd(8'h05, 8'hFF, "R8");

      // R9 status A
      wr(8'h0A, 8'hA6, 1'b0, "R9");
      rd(8'h0A, 8'h26, "R9");

      // R11 status C and D
      rd(8'h0C, 8'h00, "R11");
      rd(8'h0D, 8'h80, "R11");
      wr(8'h0D, 8'h00, 1'b0, "R11");
      rd(8'h0D, 8'h80, "R11");
      wr(8'h0C, 8'h11, 1'b1, "R11");

      // R12 RAM
      wr(8'h0E, 8'h5A, 1'b0, "R12");
      wr(8'h7F, 8'hC3, 1'b0, "R12");
      rd(8'h0E, 8'h5A, "R12");
      rd(8'h7F, 8'hC3, "R12");
      rd(8'h0F, 8'h00, "R12");

      // R1 bit 7 of index dropped
      rd(8'h8B, 8'h02, "R1");

      // R2 wrong widths
      sel(8'h0E);
      acc(1'b1, 1'b0, 2'd1, 8'h0B, 1'b0, 1'b1, 8'h00, "R2");
      acc(1'b0, 1'b1, 2'd2, 8'h00, 1'b0, 1'b1, 8'h00, "R2");
      acc(1'b0, 1'b1, 2'd0, 8'h00, 1'b1, 1'b0, 8'h5A, "R2");
      acc(1'b1, 1'b1, 2'd3, 8'h11, 1'b0, 1'b1, 8'h00, "R2");
      acc(1'b0, 1'b1, 2'd0, 8'h00, 1'b1, 1'b0, 8'h5A, "R2");

      // R6 halt freezes, refresh spacing
      wr(8'h0B, 8'h82, 1'b0, "R6");
      live_sec = 6'd33;
      repeat (2*N + 4) @(negedge clk);
      rd(8'h00, bcd(7), "R6");
      wr(8'h0B, 8'h02, 1'b0, "R6");
      sel(8'h00);
      live_sec = 6'd50;
      acc(1'b0, 1'b1, 2'd0, 8'h00, 1'b1, 1'b0, bcd(33), "R6");
      repeat (N + 4) @(negedge clk);
      acc(1'b0, 1'b1, 2'd0, 8'h00, 1'b1, 1'b0, bcd(50), "R6");

      // R4 12-hour corners
      wr(8'h0B, 8'h00, 1'b0, "R4");
      live_hour = 5'd0;
      repeat (N + 4) @(negedge clk);
      rd(8'h04, 8'h01, "R4");
      live_hour = 5'd12;
      repeat (N + 4) @(negedge clk);
      rd(8'h04, 8'h81, "R4");
      live_hour = 5'd23;
      repeat (N + 4) @(negedge clk);
      rd(8'h04, 8'h92, "R4");
      wr(8'h0B, 8'h04, 1'b0, "R4");
      rd(8'h04, 8'h8C, "R4");
      rd(8'h01, 8'hA7, "R8");

      repeat (4) @(negedge clk);
      if (q_chk.size() != 0) begin
         checks++; failures++;
         $display("FAIL R13 missing responses actual=%0d expected=0", q_chk.size());
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule